// File: doc/BRIEF.md
# Sample-to-RAM Capture Engine

This block copies a stream of samples into a window of word-addressed memory. Four sample producers feed it. Each producer has its own valid strobe, data word and event strobe, and a configuration field picks which one the engine listens to. Every valid sample from the chosen producer becomes exactly one single-cycle write on the memory port. The counter starts at a programmable first address and moves up by one per write until it reaches a programmable last address. The memory port addresses a flat space of 4480 words (0 to 4479) that covers several physical memories. The engine always has priority on this port and never waits.

A small register port configures the engine and starts it. Three modes decide what happens after a trigger. Single-pass mode fills the window once. Looping mode returns to the first address after each pass. Event mode arms the engine, and the pass starts only when the chosen producer raises its event strobe. An optional end-marker setting stores zeros in place of the sample at the last address. A status register shows whether the engine is busy and gives the current address counter.

Top module: `sample_capture`

## Requirements
- R1: After reset, every register reads zero, the busy flag is clear and no memory write occurs.
- R2: Register index 0 (config) holds bit 0 enable, bits [2:1] source select, bits [4:3] mode and bit 5 end-marker. Index 1 holds the 13-bit first address and index 2 the 13-bit last address. All three read back as written, with other bits zero.
- R3: In mode 0 (single pass, mode 3 behaves the same), writing 1 to bit 0 of index 3 while enabled and idle loads the counter with the first address. Each later valid sample is then written one cycle after it arrives, at consecutive addresses up to and including the last address. After that write the engine goes idle and the counter rests at last+1.
- R4: In mode 1 (looping), the sample written at the last address is followed by a write at the first address, and this repeats without end.
- R5: In mode 2 (event), the trigger only arms the engine, and busy reads 1 while it is armed. Valid samples are not written until the selected producer pulses its event. The counter then loads the first address and one pass runs, starting with the valid samples of the following cycles.
- R6: With the end-marker bit set, the write at the last address carries all zeros instead of the sample.
- R7: Select value s (0 to 3) makes only producer s's valid, data (bits [16s+15:16s]) and event strobe matter.
- R8: The trigger is ignored when bit 0 of the written value is 0, when the engine is disabled, and when it is already armed or running.
- R9: Clearing the enable bit returns the engine to idle at once. No write follows, and busy reads 0.
- R10: An address above 4479 is never written. A valid sample that meets such an address ends the pass as the last address would, and the counter still moves up by one.
- R11: Index 4 (status) reads busy in bit 0 and the low 12 bits of the counter in bits [27:16]. All other bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index (0 config, 1 first, 2 last, 3 trigger, 4 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| src_valid | input | 4 | Per-producer sample valid |
| src_data | input | 64 | Per-producer sample words, 16 bits each |
| src_event | input | 4 | Per-producer event strobe |
| mem_we | output | 1 | Memory write enable, one cycle per write |
| mem_addr | output | 13 | Memory word address |
| mem_wdata | output | 16 | Memory write data |

## Verification
The hardest case to reach is the top of the address space. A pass must run into the 4479 boundary with a last address that lies beyond it, so the engine has to end on the out-of-range rule and not on the last-address match. The stimulus reaches it with a directed single pass that starts a few words below the limit and sets an unreachable last address. Randomly timed samples, events on producers that are not selected, and retriggers in the middle of a pass cover the remaining cases.

// File: rtl/sample_capture.sv
module sample_capture #(
  parameter int DW         = 16,
  parameter int AW         = 13,
  parameter int ADDR_LIMIT = 4479
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [2:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic [3:0]      src_valid,
  input  logic [4*DW-1:0] src_data,
  input  logic [3:0]      src_event,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata
);
  localparam logic [AW-1:0] LIMIT = AW'(ADDR_LIMIT);
  localparam int CW = 12;
  localparam logic [1:0] M_LOOP = 2'd1, M_EVENT = 2'd2;

  typedef enum logic [1:0] {IDLE, ARMED, RUN} state_t;
  state_t state;

  logic          cfg_en, cfg_zl;
  logic [1:0]    cfg_sel, cfg_mode;
  logic [AW-1:0] first_q, last_q, cnt_q;

  wire          sel_valid = src_valid[cfg_sel];
  wire          sel_event = src_event[cfg_sel];
  wire [DW-1:0] sel_data  = src_data[cfg_sel*DW +: DW];
  wire          at_end    = (cnt_q == last_q) || (cnt_q > LIMIT);
  wire          busy      = cfg_en && (state != IDLE);
  wire          trig_hit  = reg_wr && reg_addr == 3'd3 && reg_wdata[0];
  wire          unused_hi = ^reg_wdata[31:AW];

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {26'd0, cfg_zl, cfg_mode, cfg_sel, cfg_en};
      3'd1:    reg_rdata = {{(32-AW){1'b0}}, first_q};
      3'd2:    reg_rdata = {{(32-AW){1'b0}}, last_q};
      3'd4:    reg_rdata = {4'd0, cnt_q[CW-1:0], 15'd0, busy};
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {cfg_en, cfg_zl, cfg_sel, cfg_mode} <= '0;
      first_q   <= '0;
      last_q    <= '0;
      cnt_q     <= '0;
      state     <= IDLE;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (reg_wr) begin
        case (reg_addr)
          3'd0: {cfg_zl, cfg_mode, cfg_sel, cfg_en} <= reg_wdata[5:0];
          3'd1: first_q <= reg_wdata[AW-1:0];
          3'd2: last_q  <= reg_wdata[AW-1:0];
          default: ;
        endcase
      end
      if (!cfg_en) begin
        state <= IDLE;
      end else begin
        case (state)
          IDLE: if (trig_hit) begin
            state <= (cfg_mode == M_EVENT) ? ARMED : RUN;
            cnt_q <= first_q;
          end
          ARMED: if (sel_event) begin
            state <= RUN;
            cnt_q <= first_q;
          end
          default: if (sel_valid) begin
            if (cnt_q <= LIMIT) begin
              mem_we    <= 1'b1;
              mem_addr  <= cnt_q;
              mem_wdata <= (cfg_zl && cnt_q == last_q) ? '0 : sel_data;
            end
            if (at_end && cfg_mode == M_LOOP) begin
              cnt_q <= first_q;
            end else begin
              cnt_q <= cnt_q + 1'b1;
              if (at_end) state <= IDLE;
            end
          end
        endcase
      end
    end
  end

  // R10
  limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr <= LIMIT);

  // R9
  disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> !mem_we);

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != RUN) |=> !mem_we);

  // R7
  sel_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(sel_valid));

  // R6
  zero_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(cfg_zl) && mem_addr == $past(last_q)) |-> mem_wdata == '0);
endmodule

// File: tb/sample_capture_test.sv
`timescale 1ns/1ps
module sample_capture_test;
  logic        clk = 0, rst_n = 0;
  logic        reg_wr = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [3:0]  src_valid = 0, src_event = 0;
  logic [63:0] src_data = 0;
  logic        mem_we;
  logic [12:0] mem_addr;
  logic [15:0] mem_wdata;

  sample_capture uut (.*);

  always #10 clk = ~clk;

  int nchk = 0, nfail = 0;
  string req = "R1";
  int m_en = 0, m_sel = 0, m_mode = 0, m_zl = 0, m_first = 0, m_last = 0;
  int m_state = 0, m_addr = 0;
  bit p_we = 0; int p_addr = 0, p_data = 0;

  function automatic int cfg_word(int en, int sel, int mode, int zl);
    return en | (sel << 1) | (mode << 3) | (zl << 5);
  endfunction

  function automatic int status_word();
    return ((m_addr & 12'hFFF) << 16) | ((m_state != 0) ? 1 : 0);
  endfunction

  task automatic cycle(input bit wr, input int idx, input int wd,
                       input logic [3:0] v, input logic [3:0] ev);
    @(negedge clk);
    nchk++;
    if (mem_we !== p_we || (p_we && (mem_addr !== 13'(p_addr) || mem_wdata !== 16'(p_data)))) begin
      nfail++;
      $display("FAIL %s: write we=%0b addr=%0d data=%0h, expected we=%0b addr=%0d data=%0h",
               req, mem_we, mem_addr, mem_wdata, p_we, p_addr, p_data);
    end
    reg_wr = wr; reg_addr = 3'(idx); reg_wdata = wd;
    src_valid = v; src_event = ev;
    for (int s = 0; s < 4; s++) src_data[s*16 +: 16] = 16'($urandom);
    p_we = 0;
    if (m_en != 0 && m_state == 2 && v[m_sel]) begin
      if (m_addr <= 4479) begin
        p_we = 1; p_addr = m_addr;
        p_data = (m_zl != 0 && m_addr == m_last) ? 0 : int'(src_data[m_sel*16 +: 16]);
      end
      if ((m_addr == m_last || m_addr > 4479) && m_mode == 1) m_addr = m_first;
      else begin
        if (m_addr == m_last || m_addr > 4479) m_state = 0;
        m_addr = (m_addr + 1) & 8191;
      end
    end else if (m_en != 0 && m_state == 1 && ev[m_sel]) begin
      m_state = 2; m_addr = m_first;
    end
    if (wr) begin
      case (idx)
        0: begin
          m_en = wd & 1; m_sel = (wd >> 1) & 3; m_mode = (wd >> 3) & 3; m_zl = (wd >> 5) & 1;
          if (m_en == 0) m_state = 0;
        end
        1: m_first = wd & 8191;
        2: m_last = wd & 8191;
        3: if ((wd & 1) != 0 && m_en != 0 && m_state == 0) begin
          m_state = (m_mode == 2) ? 1 : 2; m_addr = m_first;
        end
        default: ;
      endcase
    end
  endtask

  task automatic wreg(input int idx, input int wd);
    cycle(1, idx, wd, 4'd0, 4'd0);
  endtask

  task automatic rd(input int idx, input int exp);
    cycle(0, idx, 0, 4'd0, 4'd0);
    #1;
    nchk++;
    if (reg_rdata !== 32'(exp)) begin
      nfail++;
      $display("FAIL %s: reg %0d read %0h, expected %0h", req, idx, reg_rdata, exp);
    end
  endtask

  task automatic feed(input int n, input int pv, input int pe);
    for (int i = 0; i < n; i++) begin
      logic [3:0] v, e;
      for (int b = 0; b < 4; b++) begin
        v[b] = ($urandom % 100) < pv;
        e[b] = ($urandom % 100) < pe;
      end
      cycle(0, 0, 0, v, e);
    end
  endtask

  initial begin
    #(200000 * 20);
    nfail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    req = "R1";
    rd(0, 0); rd(1, 0); rd(2, 0); rd(4, 0);

    req = "R2";
    wreg(0, cfg_word(1, 2, 1, 1)); rd(0, cfg_word(1, 2, 1, 1));
    wreg(1, 32'hFFFF_E00A); rd(1, 13'h000A);
    wreg(2, 4479); rd(2, 4479);

    req = "R3";
    wreg(0, cfg_word(1, 1, 0, 0)); wreg(1, 10); wreg(2, 17);
    wreg(3, 1); rd(4, status_word());
    feed(40, 50, 0);
    req = "R11"; rd(4, status_word());

    req = "R6";
    wreg(0, cfg_word(1, 3, 0, 1)); wreg(3, 1);
    feed(30, 70, 0); rd(4, status_word());

    req = "R4";
    wreg(0, cfg_word(1, 0, 1, 0)); wreg(1, 100); wreg(2, 103);
    wreg(3, 1); feed(20, 60, 0);
    req = "R8"; wreg(3, 1); feed(10, 60, 0); rd(4, status_word());
    req = "R9"; wreg(0, cfg_word(0, 0, 1, 0)); feed(10, 100, 0); rd(4, status_word());
    req = "R8"; wreg(3, 1); feed(5, 100, 0); rd(4, status_word());
    wreg(0, cfg_word(1, 0, 0, 0)); wreg(3, 0); feed(5, 100, 0); rd(4, status_word());

    req = "R5";
    wreg(0, cfg_word(1, 2, 2, 0)); wreg(1, 200); wreg(2, 205);
    wreg(3, 1); rd(4, status_word());
    feed(8, 100, 0);
    req = "R7"; cycle(0, 0, 0, 4'hF, 4'b1011); feed(4, 100, 0);
    req = "R5"; cycle(0, 0, 0, 4'h0, 4'b0100); feed(15, 80, 0); rd(4, status_word());

    req = "R10";
    wreg(0, cfg_word(1, 1, 0, 1)); wreg(1, 4476); wreg(2, 6000);
    wreg(3, 1); feed(12, 100, 0); rd(4, status_word());

    req = "R7";
    for (int k = 0; k < 40; k++) begin
      int f = $urandom % 4400;
      wreg(0, cfg_word(1, $urandom % 4, $urandom % 3, $urandom % 2));
      wreg(1, f); wreg(2, f + ($urandom % 8));
      wreg(3, 1);
      feed(30, 60, 10);
      rd(4, status_word());
      wreg(0, 0);
    end
    cycle(0, 0, 0, 4'd0, 4'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule